// File: doc/BRIEF.md
# Triggered Three-Channel Capture Controller

This block records a burst of 1024 sample frames into an on-block memory. Each frame holds three signed channels: one acceleration channel and two auxiliary channels. A single start/stop command drives three capture modes. The manual mode records one burst on command. The periodic mode records a burst, waits a programmed interval, and repeats. The event mode records continuously into a ring until a channel crosses its alarm threshold. It keeps a chosen amount of history from before that moment, then stops once the ring holds the rest of the burst.

After a burst ends, a host reads the result one frame at a time through a readout position. The position returns to 0 when a burst completes. Each read of capture data moves it forward by one. The host can also load it directly or clear it with a command. In event mode, position 0 always maps to the oldest retained pre-trigger frame, so the host sees one time-ordered record in every mode. A busy output covers the whole capture. A sticky flag records any host access made while busy, and sticky per-channel flags record which thresholds were exceeded.

The memory depth must be a power of two. Periodic timing is derived from the `CLKS_PER_SEC` parameter.

Top module: `trig_capture_ctrl`

## Requirements
- R1: After reset: `busy`, `data_ready`, `trig_flags` and `cap_violation` are 0, and `rd_ptr` is 0.
- R2: With `cfg_mode` 00 (or 11, treated the same), a `cmd_start_stop` pulse raises `busy` on the next cycle.
  - Each cycle with `smp_valid` high then stores one frame at the next position, starting at 0. Cycles without `smp_valid` store nothing.
  - After the 1024th stored frame, `busy` falls, `data_ready` becomes 1 and `rd_ptr` becomes 0.
- R3: A `cmd_start_stop` pulse while `busy` is high aborts the capture. `busy` falls on the next cycle and `data_ready` stays 0.
- R4: With `cfg_mode` 01, the first burst starts immediately on the start pulse.
  - After each burst, the next one begins `cfg_prd_count` × unit later, where the unit is set by `cfg_prd_scale`: 00 = 1 s, 01 = 60 s, 10/11 = 3600 s, and 1 s = `CLKS_PER_SEC` cycles. The idle gap lasts count × unit + 1 cycles.
  - A start/stop pulse during that wait ends the mode, and no further burst starts.
- R5: With `cfg_mode` 10, a start pulse arms the block (`busy` high). A frame triggers when any enabled channel's sample is strictly greater, as signed values, than that channel's threshold.
  - The enable bits are bit0 = acceleration, bit1 = aux 1, bit2 = aux 2.
  - A crossing is ignored until at least the pre-trigger length of frames has been stored since the start. Crossings on disabled channels are always ignored.
- R6: `cfg_pre_sel` selects the pre-trigger length: 00 = 64, 01 = 128, 10 = 256, 11 = 512.
  - The triggering frame and the frames after it fill the remaining 1024 − length positions, and then the burst completes.
  - Readout position 0 returns the frame stored length frames before the trigger. Position `length` returns the triggering frame, and position 1023 returns the last frame stored.
- R7: `trig_flags` (bit0 acceleration, bit1 aux 1, bit2 aux 2) are sticky.
  - A bit is set when its enabled channel exceeds its threshold on a stored frame, either during a linear burst or during the event post-trigger phase. In event mode, the triggering frame also sets the bits of the channels that caused the trigger.
  - All bits clear when a capture starts or on a `cmd_clr_status` pulse.
- R8: A `rd_step` pulse increments `rd_ptr` by one, wrapping from 1023 to 0. `ptr_load` loads `ptr_load_val`, and `cmd_ptr_reset` sets the pointer to 0. The `rd_*` outputs show the frame at the current position in the same cycle.
- R9: In manual mode (00 or 11) and while idle, a falling edge on `ext_trig` starts a capture, with `busy` high 3 cycles after the fall. A rising edge alone starts nothing, and `ext_trig` is ignored in the other modes.
- R10: A `host_access` pulse while `busy` is high sets `cap_violation`, which stays set until a `cmd_clr_status` pulse. An access while idle does not set it.
- R11: `data_ready` returns to 0 when a new capture starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | New frame present on the sample inputs |
| smp_acc | input | 16 | Acceleration sample, signed |
| smp_ain1 | input | 16 | Aux 1 sample, signed |
| smp_ain2 | input | 16 | Aux 2 sample, signed |
| cfg_mode | input | 2 | 00 manual, 01 periodic, 10 event, 11 manual |
| cfg_pre_sel | input | 2 | Event pre-trigger length code |
| cfg_prd_count | input | 8 | Periodic interval in units |
| cfg_prd_scale | input | 2 | Periodic unit code |
| cfg_alarm_en | input | 3 | Per-channel alarm enables |
| thr_acc | input | 16 | Acceleration threshold, signed |
| thr_ain1 | input | 16 | Aux 1 threshold, signed |
| thr_ain2 | input | 16 | Aux 2 threshold, signed |
| cmd_start_stop | input | 1 | Start/stop command pulse |
| cmd_clr_status | input | 1 | Clears trigger and violation flags |
| cmd_ptr_reset | input | 1 | Clears the readout position |
| ptr_load | input | 1 | Loads the readout position |
| ptr_load_val | input | 10 | Value for `ptr_load` |
| rd_step | input | 1 | Capture-data read, advances the position |
| host_access | input | 1 | Any host register access |
| ext_trig | input | 1 | External trigger, asynchronous |
| busy | output | 1 | Capture in progress |
| data_ready | output | 1 | Completed burst available |
| rd_ptr | output | 10 | Readout position |
| rd_acc | output | 16 | Acceleration frame at the position |
| rd_ain1 | output | 16 | Aux 1 frame at the position |
| rd_ain2 | output | 16 | Aux 2 frame at the position |
| trig_flags | output | 3 | Sticky threshold flags |
| cap_violation | output | 1 | Sticky access-while-busy flag |

## Verification
The event run places an over-threshold spike before the pre-trigger history is full, and drives a disabled channel far above its threshold. A design that fired early, or watched every channel, would end the burst at the wrong frame count and return the wrong oldest frame at position 0. The run also reads the frames at positions 0, 127, 128 and 1023. A ring rotated by the wrong amount, or off by one at the trigger, shows up as wrong values at these boundaries. Periodic runs measure the idle gap, both in seconds and in minutes, and send a stop during the wait, so a miscounted prescaler, a wrong scale or a stop that the wait state ignores appears as a gap of the wrong length or as an extra burst. Manual bursts include gaps in `smp_valid` and a pointer wrap from 1023, and an abort is checked to leave `data_ready` low.

// File: rtl/capture_pkg.sv
package capture_pkg;

    parameter int CAP_DW  = 16;
    parameter int CAP_NCH = 3;

    typedef logic [CAP_NCH-1:0][CAP_DW-1:0] frame_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_WAIT,
        ST_ARM,
        ST_POST
    } cap_state_e;

    typedef enum logic [1:0] {
        MODE_MANUAL = 2'b00,
        MODE_AUTO   = 2'b01,
        MODE_EVENT  = 2'b10,
        MODE_SPARE  = 2'b11
    } cap_mode_e;

    function automatic int unsigned pre_depth(input logic [1:0] code);
        return 32'd64 << code;
    endfunction

    function automatic int unsigned secs_per_unit(input logic [1:0] scale);
        case (scale)
            2'b00:   return 1;
            2'b01:   return 60;
            default: return 3600;
        endcase
    endfunction

endpackage

// File: rtl/cap_alarm.sv
module cap_alarm
    import capture_pkg::*;
(
    input  frame_t               smp,
    input  frame_t               thr,
    input  logic [CAP_NCH-1:0]   en,
    output logic [CAP_NCH-1:0]   hit
);

    for (genvar g = 0; g < CAP_NCH; g++) begin : g_chan
        assign hit[g] = en[g] && ($signed(smp[g]) > $signed(thr[g]));
    end

endmodule

// File: rtl/cap_sample_ram.sv
module cap_sample_ram
    import capture_pkg::*;
#(
    parameter int unsigned DEPTH = 1024,
    parameter int          AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  frame_t        wdata,
    input  logic [AW-1:0] raddr,
    output frame_t        rdata
);

    for (genvar g = 0; g < CAP_NCH; g++) begin : g_lane
        logic [CAP_DW-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we) begin
                mem[waddr] <= wdata[g];
            end
        end

        assign rdata[g] = mem[raddr];
    end

endmodule

// File: rtl/cap_period_timer.sv
module cap_period_timer
    import capture_pkg::*;
#(
    parameter int unsigned CLKS_PER_SEC = 100_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic [7:0] prd_count,
    input  logic [1:0] prd_scale,
    output logic       expired
);

    localparam int PW = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;
    localparam int SW = 12;

    logic [PW-1:0] pre_q;
    logic [SW-1:0] sec_q;
    logic [7:0]    unit_q;
    logic          sec_tick;
    logic          unit_tick;

    assign sec_tick  = (pre_q == PW'(CLKS_PER_SEC - 1));
    assign unit_tick = sec_tick && (sec_q == SW'(secs_per_unit(prd_scale) - 1));
    assign expired   = run && (unit_q == prd_count);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pre_q  <= '0;
            sec_q  <= '0;
            unit_q <= '0;
        end else begin
            pre_q <= sec_tick ? '0 : pre_q + PW'(1);
            if (sec_tick) begin
                sec_q <= unit_tick ? '0 : sec_q + SW'(1);
            end
            if (unit_tick) begin
                unit_q <= unit_q + 8'd1;
            end
        end
    end

    // R4: the interval counter only ever moves by one unit per cycle
    p_unit_step_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && run) |-> (unit_q == $past(unit_q) || unit_q == $past(unit_q) + 8'd1));

endmodule

// File: rtl/trig_capture_ctrl.sv
module trig_capture_ctrl
    import capture_pkg::*;
#(
    parameter int unsigned DEPTH        = 1024,
    parameter int unsigned CLKS_PER_SEC = 100_000_000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      smp_valid,
    input  logic [CAP_DW-1:0]         smp_acc,
    input  logic [CAP_DW-1:0]         smp_ain1,
    input  logic [CAP_DW-1:0]         smp_ain2,
    input  logic [1:0]                cfg_mode,
    input  logic [1:0]                cfg_pre_sel,
    input  logic [7:0]                cfg_prd_count,
    input  logic [1:0]                cfg_prd_scale,
    input  logic [CAP_NCH-1:0]        cfg_alarm_en,
    input  logic [CAP_DW-1:0]         thr_acc,
    input  logic [CAP_DW-1:0]         thr_ain1,
    input  logic [CAP_DW-1:0]         thr_ain2,
    input  logic                      cmd_start_stop,
    input  logic                      cmd_clr_status,
    input  logic                      cmd_ptr_reset,
    input  logic                      ptr_load,
    input  logic [$clog2(DEPTH)-1:0]  ptr_load_val,
    input  logic                      rd_step,
    input  logic                      host_access,
    input  logic                      ext_trig,
    output logic                      busy,
    output logic                      data_ready,
    output logic [$clog2(DEPTH)-1:0]  rd_ptr,
    output logic [CAP_DW-1:0]         rd_acc,
    output logic [CAP_DW-1:0]         rd_ain1,
    output logic [CAP_DW-1:0]         rd_ain2,
    output logic [CAP_NCH-1:0]        trig_flags,
    output logic                      cap_violation
);

    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    cap_state_e          state_q;
    logic [AW-1:0]       wr_idx_q;
    logic [AW-1:0]       base_q;
    logic [AW-1:0]       rd_ptr_q;
    logic [CW-1:0]       fill_q;
    logic [CW-1:0]       post_q;
    logic [CW-1:0]       pre_len;
    logic [CW-1:0]       post_total;
    logic [1:0]          pre_sel_q;
    logic                auto_q;
    logic                ready_q;
    logic                viol_q;
    logic [CAP_NCH-1:0]  flags_q;
    logic [CAP_NCH-1:0]  hit;
    logic                ext_s1, ext_s2, ext_s3;
    logic                ext_fall;
    logic                manual_sel;
    logic                ext_start;
    logic                wr_en;
    logic                trig_now;
    logic                cap_done;
    logic                timer_exp;
    frame_t              smp_f;
    frame_t              thr_f;
    frame_t              rd_f;

    assign smp_f = {smp_ain2, smp_ain1, smp_acc};
    assign thr_f = {thr_ain2, thr_ain1, thr_acc};

    cap_alarm i_alarm (
        .smp (smp_f),
        .thr (thr_f),
        .en  (cfg_alarm_en),
        .hit (hit)
    );

    cap_sample_ram #(.DEPTH(DEPTH), .AW(AW)) i_ram (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_idx_q),
        .wdata (smp_f),
        .raddr (base_q + rd_ptr_q),
        .rdata (rd_f)
    );

    cap_period_timer #(.CLKS_PER_SEC(CLKS_PER_SEC)) i_timer (
        .clk       (clk),
        .rst       (rst),
        .run       (state_q == ST_WAIT),
        .prd_count (cfg_prd_count),
        .prd_scale (cfg_prd_scale),
        .expired   (timer_exp)
    );

    assign pre_len    = CW'(pre_depth(pre_sel_q));
    assign post_total = CW'(DEPTH) - pre_len;
    assign manual_sel = (cfg_mode == MODE_MANUAL) || (cfg_mode == MODE_SPARE);
    assign ext_fall   = ext_s3 && !ext_s2;
    assign ext_start  = (state_q == ST_IDLE) && manual_sel && ext_fall;

    assign wr_en    = smp_valid && !cmd_start_stop &&
                      (state_q == ST_FILL || state_q == ST_ARM || state_q == ST_POST);
    assign trig_now = (state_q == ST_ARM) && wr_en && (|hit) && (fill_q >= pre_len);
    assign cap_done = wr_en &&
                      ((state_q == ST_FILL && wr_idx_q == AW'(DEPTH - 1)) ||
                       (state_q == ST_POST && post_q == post_total - CW'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            ext_s1 <= 1'b0;
            ext_s2 <= 1'b0;
            ext_s3 <= 1'b0;
        end else begin
            ext_s1 <= ext_trig;
            ext_s2 <= ext_s1;
            ext_s3 <= ext_s2;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            wr_idx_q  <= '0;
            base_q    <= '0;
            fill_q    <= '0;
            post_q    <= '0;
            pre_sel_q <= '0;
            auto_q    <= 1'b0;
            ready_q   <= 1'b0;
            flags_q   <= '0;
            viol_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (cmd_start_stop || ext_start) begin
                        flags_q   <= '0;
                        ready_q   <= 1'b0;
                        wr_idx_q  <= '0;
                        base_q    <= '0;
                        fill_q    <= '0;
                        pre_sel_q <= cfg_pre_sel;
                        auto_q    <= cmd_start_stop && (cfg_mode == MODE_AUTO);
                        state_q   <= (cmd_start_stop && cfg_mode == MODE_EVENT) ? ST_ARM : ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (cmd_start_stop) begin
                        state_q <= ST_IDLE;
                    end else if (smp_valid) begin
                        flags_q <= flags_q | hit;
                        if (cap_done) begin
                            ready_q <= 1'b1;
                            state_q <= auto_q ? ST_WAIT : ST_IDLE;
                        end else begin
                            wr_idx_q <= wr_idx_q + AW'(1);
                        end
                    end
                end
                ST_WAIT: begin
                    if (cmd_start_stop) begin
                        state_q <= ST_IDLE;
                    end else if (timer_exp) begin
                        flags_q  <= '0;
                        ready_q  <= 1'b0;
                        wr_idx_q <= '0;
                        state_q  <= ST_FILL;
                    end
                end
                ST_ARM: begin
                    if (cmd_start_stop) begin
                        state_q <= ST_IDLE;
                    end else if (smp_valid) begin
                        wr_idx_q <= wr_idx_q + AW'(1);
                        if (trig_now) begin
                            flags_q <= flags_q | hit;
                            base_q  <= wr_idx_q - pre_len[AW-1:0];
                            post_q  <= CW'(1);
                            state_q <= ST_POST;
                        end else if (fill_q < pre_len) begin
                            fill_q <= fill_q + CW'(1);
                        end
                    end
                end
                ST_POST: begin
                    if (cmd_start_stop) begin
                        state_q <= ST_IDLE;
                    end else if (smp_valid) begin
                        wr_idx_q <= wr_idx_q + AW'(1);
                        flags_q  <= flags_q | hit;
                        if (cap_done) begin
                            ready_q <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            post_q <= post_q + CW'(1);
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase

            if (host_access && busy) begin
                viol_q <= 1'b1;
            end
            if (cmd_clr_status) begin
                flags_q <= '0;
                viol_q  <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr_q <= '0;
        end else if (cap_done || cmd_ptr_reset) begin
            rd_ptr_q <= '0;
        end else if (ptr_load) begin
            rd_ptr_q <= ptr_load_val;
        end else if (rd_step) begin
            rd_ptr_q <= rd_ptr_q + AW'(1);
        end
    end

    assign busy          = (state_q == ST_FILL) || (state_q == ST_ARM) || (state_q == ST_POST);
    assign data_ready    = ready_q;
    assign rd_ptr        = rd_ptr_q;
    assign rd_acc        = rd_f[0];
    assign rd_ain1       = rd_f[1];
    assign rd_ain2       = rd_f[2];
    assign trig_flags    = flags_q;
    assign cap_violation = viol_q;

    // R3: a stop during a capture ends it without marking data ready
    p_stop_abort_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_start_stop) |=> (!busy && !data_ready));

    // R2: a completed burst always presents position 0
    p_done_ptr_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(data_ready) |-> (rd_ptr == '0));

    // R11: every new capture begins with data_ready low
    p_start_clear_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !data_ready);

    // R10: an access while busy is recorded
    p_violation_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && host_access && !cmd_clr_status) |=> cap_violation);

    // R6: the post-trigger phase is entered only with full history
    p_trig_fill_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_POST && $past(state_q) == ST_ARM) |-> ($past(fill_q) >= $past(pre_len)));

    // R8: a plain read step advances the position by one
    p_ptr_step_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_step && !ptr_load && !cmd_ptr_reset && !cap_done) |=> (rd_ptr == AW'($past(rd_ptr) + AW'(1))));

    // R7: flags hold while idle and untouched
    p_flags_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && !cmd_start_stop && !ext_start && !cmd_clr_status) |=> $stable(trig_flags));

endmodule

// File: tb/test_trig_capture_ctrl.sv
module test_trig_capture_ctrl;

    localparam int CPS = 5;

    logic        clk = 1'b0;
    logic        rst;
    logic        smp_valid;
    logic [15:0] smp_acc, smp_ain1, smp_ain2;
    logic [1:0]  cfg_mode, cfg_pre_sel, cfg_prd_scale;
    logic [7:0]  cfg_prd_count;
    logic [2:0]  cfg_alarm_en;
    logic [15:0] thr_acc, thr_ain1, thr_ain2;
    logic        cmd_start_stop, cmd_clr_status, cmd_ptr_reset, ptr_load;
    logic [9:0]  ptr_load_val;
    logic        rd_step, host_access, ext_trig;
    logic        busy, data_ready, cap_violation;
    logic [9:0]  rd_ptr;
    logic [15:0] rd_acc, rd_ain1, rd_ain2;
    logic [2:0]  trig_flags;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    trig_capture_ctrl #(.DEPTH(1024), .CLKS_PER_SEC(CPS)) i_trig_capture_ctrl (
        .clk(clk), .rst(rst), .smp_valid(smp_valid),
        .smp_acc(smp_acc), .smp_ain1(smp_ain1), .smp_ain2(smp_ain2),
        .cfg_mode(cfg_mode), .cfg_pre_sel(cfg_pre_sel), .cfg_prd_count(cfg_prd_count),
        .cfg_prd_scale(cfg_prd_scale), .cfg_alarm_en(cfg_alarm_en),
        .thr_acc(thr_acc), .thr_ain1(thr_ain1), .thr_ain2(thr_ain2),
        .cmd_start_stop(cmd_start_stop), .cmd_clr_status(cmd_clr_status),
        .cmd_ptr_reset(cmd_ptr_reset), .ptr_load(ptr_load), .ptr_load_val(ptr_load_val),
        .rd_step(rd_step), .host_access(host_access), .ext_trig(ext_trig),
        .busy(busy), .data_ready(data_ready), .rd_ptr(rd_ptr),
        .rd_acc(rd_acc), .rd_ain1(rd_ain1), .rd_ain2(rd_ain2),
        .trig_flags(trig_flags), .cap_violation(cap_violation)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic pulse_start();
        cmd_start_stop = 1'b1; step(); cmd_start_stop = 1'b0;
    endtask

    task automatic drive(input int a, input int b, input int c);
        smp_valid = 1'b1;
        smp_acc   = 16'(a);
        smp_ain1  = 16'(b);
        smp_ain2  = 16'(c);
    endtask

    task automatic load_ptr(input int p);
        ptr_load_val = 10'(p); ptr_load = 1'b1; step(); ptr_load = 1'b0;
    endtask

    task automatic check_frame(input string req, input int a, input int b, input int c);
        check({req, " acc"},  int'($signed(rd_acc)),  a);
        check({req, " ain1"}, int'($signed(rd_ain1)), b);
        check({req, " ain2"}, int'($signed(rd_ain2)), c);
    endtask

    task automatic run_until(input logic lvl, output int cycles);
        smp_valid = 1'b1;
        cycles = 0;
        while (busy != lvl && cycles < 5000) begin
            step();
            cycles++;
        end
    endtask

    task automatic t_reset();
        check("R1 busy", int'(busy), 0);
        check("R1 data_ready", int'(data_ready), 0);
        check("R1 rd_ptr", int'(rd_ptr), 0);
        check("R1 trig_flags", int'(trig_flags), 0);
        check("R1 cap_violation", int'(cap_violation), 0);
    endtask

    task automatic t_manual();
        int k = 0;
        int cyc = 0;
        cfg_mode = 2'b00; cfg_alarm_en = 3'b111;
        thr_acc = 16'd1000; thr_ain1 = 16'd0; thr_ain2 = 16'h7FFF;
        pulse_start();
        check("R2 busy after start", int'(busy), 1);
        while (k < 1023) begin
            if (cyc % 7 == 6) smp_valid = 1'b0;
            else begin drive(2 * k, -k, 3 * k - 1500); k++; end
            step();
            cyc++;
        end
        smp_valid = 1'b0; step();
        check("R2 busy before last frame", int'(busy), 1);
        drive(2 * 1023, -1023, 3 * 1023 - 1500); step(); smp_valid = 1'b0;
        check("R2 busy after 1024", int'(busy), 0);
        check("R2 data_ready", int'(data_ready), 1);
        check("R2 rd_ptr", int'(rd_ptr), 0);
        check("R7 flags manual", int'(trig_flags), 1);
        check_frame("R2 pos0", 0, 0, -1500);
        rd_step = 1'b1; step(); rd_step = 1'b0;
        check("R8 step", int'(rd_ptr), 1);
        check_frame("R8 pos1", 2, -1, -1497);
        load_ptr(6);
        check_frame("R2 pos6", 12, -6, -1482);
        load_ptr(1023);
        check("R8 load", int'(rd_ptr), 1023);
        check_frame("R8 pos1023", 2046, -1023, 1569);
        rd_step = 1'b1; step(); rd_step = 1'b0;
        check("R8 wrap", int'(rd_ptr), 0);
        load_ptr(500);
        cmd_ptr_reset = 1'b1; step(); cmd_ptr_reset = 1'b0;
        check("R8 ptr reset", int'(rd_ptr), 0);
    endtask

    task automatic t_abort();
        host_access = 1'b1; step(); host_access = 1'b0;
        check("R10 idle access", int'(cap_violation), 0);
        pulse_start();
        check("R11 ready cleared", int'(data_ready), 0);
        check("R7 flags cleared at start", int'(trig_flags), 0);
        for (int i = 0; i < 10; i++) begin drive(2000, 0, 0); step(); end
        smp_valid = 1'b0;
        host_access = 1'b1; step(); host_access = 1'b0;
        check("R10 busy access", int'(cap_violation), 1);
        pulse_start();
        check("R3 busy after stop", int'(busy), 0);
        check("R3 data_ready after stop", int'(data_ready), 0);
        repeat (4) step();
        check("R3 stays idle", int'(busy), 0);
        check("R7 flags sticky", int'(trig_flags), 1);
        check("R10 violation sticky", int'(cap_violation), 1);
        cmd_clr_status = 1'b1; step(); cmd_clr_status = 1'b0;
        check("R7 clear command", int'(trig_flags), 0);
        check("R10 clear command", int'(cap_violation), 0);
    endtask

    task automatic t_event();
        int k = 0;
        int a;
        cfg_mode = 2'b10; cfg_pre_sel = 2'b01; cfg_alarm_en = 3'b001;
        thr_acc = 16'd5000; thr_ain1 = 16'hFF9C;
        pulse_start();
        check("R5 armed busy", int'(busy), 1);
        while (busy && k < 3000) begin
            a = (k == 10) ? 7000 : (k == 300) ? 6000 : (k % 1000);
            drive(a, 2000, -k);
            k++;
            step();
            if (k == 200) begin
                check("R5 early spike ignored", int'(busy), 1);
                check("R5 no flags before trigger", int'(trig_flags), 0);
            end
        end
        smp_valid = 1'b0;
        check("R6 frames until done", k, 1196);
        check("R5 flags event", int'(trig_flags), 1);
        check("R6 data_ready", int'(data_ready), 1);
        check_frame("R6 pos0", 172, 2000, -172);
        load_ptr(127);
        check("R6 pos127 acc", int'($signed(rd_acc)), 299);
        load_ptr(128);
        check_frame("R6 pos128", 6000, 2000, -300);
        load_ptr(1023);
        check_frame("R6 pos1023", 195, 2000, -1195);
    endtask

    task automatic t_auto();
        int c;
        cfg_mode = 2'b01; cfg_prd_scale = 2'b00; cfg_prd_count = 8'd2; cfg_alarm_en = 3'b000;
        pulse_start();
        check("R4 first burst immediate", int'(busy), 1);
        run_until(1'b0, c);
        run_until(1'b1, c);
        check("R4 gap seconds", c, 2 * CPS + 1);
        check("R11 ready cleared on repeat", int'(data_ready), 0);
        run_until(1'b0, c);
        step();
        smp_valid = 1'b0;
        pulse_start();
        c = 0;
        for (int i = 0; i < 100; i++) begin
            smp_valid = 1'b1; step();
            if (busy) c++;
        end
        check("R4 stop in wait", c, 0);
        cfg_prd_scale = 2'b01; cfg_prd_count = 8'd1;
        smp_valid = 1'b0;
        pulse_start();
        check("R4 first burst minutes", int'(busy), 1);
        run_until(1'b0, c);
        run_until(1'b1, c);
        check("R4 gap minutes", c, 60 * CPS + 1);
        smp_valid = 1'b0;
        pulse_start();
        check("R3 stop periodic", int'(busy), 0);
    endtask

    task automatic t_ext();
        cfg_mode = 2'b11;
        ext_trig = 1'b1; repeat (4) step();
        check("R9 rising edge no start", int'(busy), 0);
        ext_trig = 1'b0; repeat (3) step();
        check("R9 falling edge start", int'(busy), 1);
        pulse_start();
        check("R9 stopped", int'(busy), 0);
        cfg_mode = 2'b01;
        ext_trig = 1'b1; repeat (4) step();
        ext_trig = 1'b0; repeat (6) step();
        check("R9 ignored in periodic mode", int'(busy), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        report();
        $finish;
    end

    initial begin
        rst = 1'b1;
        smp_valid = 1'b0; smp_acc = '0; smp_ain1 = '0; smp_ain2 = '0;
        cfg_mode = 2'b00; cfg_pre_sel = 2'b00; cfg_prd_scale = 2'b00; cfg_prd_count = '0;
        cfg_alarm_en = '0; thr_acc = '0; thr_ain1 = '0; thr_ain2 = '0;
        cmd_start_stop = 1'b0; cmd_clr_status = 1'b0; cmd_ptr_reset = 1'b0;
        ptr_load = 1'b0; ptr_load_val = '0; rd_step = 1'b0; host_access = 1'b0; ext_trig = 1'b0;
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_manual();
        t_abort();
        t_event();
        t_auto();
        t_ext();
        report();
        $finish;
    end

endmodule